// File: doc/BRIEF.md
# Main Oscillator Startup Timer and Frequency Meter

This block waits out the startup time of the main oscillator and then measures how fast the main clock runs. It uses the slow clock as its time base. When `osc_en` rises, a counter in the slow-clock domain counts the startup interval given on `startup_cnt`. At the end of that interval it raises `osc_stable`.

At the same slow-clock edge that raises `osc_stable`, the block opens a gate that lasts exactly sixteen slow-clock periods. The gate is carried into the main-clock domain by a two-flop synchronizer. A counter in that domain counts the main-clock cycles that fall inside the gate, and the counter saturates rather than wrapping. When the gate closes, the main domain stores the result in a hold register and raises an acknowledge level. That level is synchronized back into the slow domain. The slow domain then copies the held value to `meas_count` and raises `meas_ready`.

Software reads `meas_count` only after `meas_ready` is set. Dropping `osc_en` returns the block to its idle state at once. One measurement is taken for each enable.

Top module: `osc_freq_meter`

## Requirements
- R1: While `rst_n` is low, `osc_stable`, `meas_ready` and `meas_count` are all 0.
- R2: `osc_stable` rises at the N-th consecutive slow-clock rising edge at which `osc_en` is sampled high. N is the value of `startup_cnt`, and a value of 0 is treated as 1. The full 8-bit range is supported, including 56.
- R3: Once set, `osc_stable` stays high for as long as `osc_en` stays high.
- R4: The gate opens at the slow edge that raises `osc_stable` and closes 16 slow periods later. The reported count is the number of main-clock rising edges inside the gate; with the main clock running at a constant integer multiple of the slow clock, this is 16 × T_slow / T_main.
- R5: When the main clock runs at least four times faster than the slow clock, `meas_ready` rises at the 19th slow edge after the edge that raised `osc_stable`. It is never high while `osc_stable` is low.
- R6: `meas_count` reads 0 while `meas_ready` is low. While `meas_ready` stays high, `meas_count` does not change.
- R7: If the gate holds 65535 or more main-clock edges, the count saturates at 65535 instead of wrapping.
- R8: A slow edge that samples `osc_en` low clears `osc_stable`, `meas_ready` and `meas_count` at that edge. This holds even when the edge would otherwise have captured the count.
- R9: After `osc_en` is dropped and raised again, a fresh startup interval and a fresh measurement follow. The new result does not depend on any earlier window, whether that window was complete or aborted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| slow_clk | input | 1 | Slow reference clock; startup and gate timing run on it |
| main_clk | input | 1 | Main clock under measurement |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| osc_en | input | 1 | Oscillator enable; low returns the block to idle |
| startup_cnt | input | 8 | Startup interval in slow-clock cycles (0 acts as 1) |
| osc_stable | output | 1 | Startup interval has elapsed |
| meas_ready | output | 1 | Measured count is valid |
| meas_count | output | 16 | Main-clock cycles counted in the 16-slow-cycle gate |

## Verification
Two functions can fall on the same slow edge. The first is a disable, which clears all outputs. The second is the capture of the synchronized result, which raises `meas_ready`. To provoke the collision, the bench watches its reference model until the cycle before the expected capture edge and drops `osc_en` at that point. It then judges that `meas_ready` and `meas_count` stay at zero on that edge and afterwards. A second collision is built in by design: the startup interval ends and the gate opens on one edge. This is judged through the exact counts obtained at several clock ratios. The bench also aborts a window part-way and then checks that the following measurement is clean.

// File: rtl/ofm_pkg.sv
package ofm_pkg;
  typedef enum logic [1:0] {
    PH_START = 2'd0,
    PH_OPEN  = 2'd1,
    PH_WAIT  = 2'd2,
    PH_DONE  = 2'd3
  } phase_t;
endpackage

// File: rtl/ofm_rst_sync.sv
// Asynchronous assert, synchronous release of an active-low reset.
module ofm_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/ofm_sync2.sv
// Two-flop level synchronizer.
module ofm_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/ofm_main_counter.sv
// Main-clock domain: counts edges while the synchronized gate is high,
// freezes the result on gate fall and raises a level acknowledge.
module ofm_main_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate_s,
  output logic [CNT_W-1:0] held_cnt,
  output logic             done_lvl
);
  localparam logic [CNT_W-1:0] SAT = {CNT_W{1'b1}};

  logic             gate_d_q, gate_d_n;
  logic [CNT_W-1:0] run_q, run_n;
  logic [CNT_W-1:0] hold_q, hold_n;
  logic             ack_q, ack_n;

  always_comb begin
    gate_d_n = gate_s;
    run_n    = run_q;
    hold_n   = hold_q;
    ack_n    = ack_q;
    if (gate_s && !gate_d_q) begin
      run_n = CNT_W'(1);
      ack_n = 1'b0;
    end else if (gate_s) begin
      run_n = (run_q == SAT) ? SAT : run_q + CNT_W'(1);
    end
    if (!gate_s && gate_d_q) begin
      hold_n = run_q;
      ack_n  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_d_q <= 1'b0;
      run_q    <= '0;
      hold_q   <= '0;
      ack_q    <= 1'b0;
    end else begin
      gate_d_q <= gate_d_n;
      run_q    <= run_n;
      hold_q   <= hold_n;
      ack_q    <= ack_n;
    end
  end

  assign held_cnt = hold_q;
  assign done_lvl = ack_q;
endmodule

// File: rtl/ofm_slow_ctrl.sv
// Slow-clock domain: startup timer, gate window and result capture.
module ofm_slow_ctrl
  import ofm_pkg::*;
#(
  parameter int START_W = 8,
  parameter int CNT_W   = 16,
  parameter int WIN_LEN = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               osc_en,
  input  logic [START_W-1:0] startup_cnt,
  input  logic               ack_s,
  input  logic [CNT_W-1:0]   held_cnt,
  output logic               gate,
  output logic               osc_stable,
  output logic               meas_ready,
  output logic [CNT_W-1:0]   meas_count
);
  localparam int               WIN_W    = (WIN_LEN > 2) ? $clog2(WIN_LEN) : 1;
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_LEN - 1);

  phase_t             ph_q, ph_n;
  logic [START_W-1:0] scnt_q, scnt_n;
  logic [WIN_W-1:0]   wcnt_q, wcnt_n;
  logic               gate_q, gate_n;
  logic               stab_q, stab_n;
  logic               rdy_q, rdy_n;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic [START_W:0]   target;
  logic               reached;

  assign target  = (startup_cnt == '0) ? (START_W+1)'(1) : {1'b0, startup_cnt};
  assign reached = ({1'b0, scnt_q} + (START_W+1)'(1)) >= target;

  always_comb begin
    ph_n   = ph_q;
    scnt_n = scnt_q;
    wcnt_n = wcnt_q;
    gate_n = gate_q;
    stab_n = stab_q;
    rdy_n  = rdy_q;
    cnt_n  = cnt_q;
    if (!osc_en) begin
      ph_n   = PH_START;
      scnt_n = '0;
      wcnt_n = '0;
      gate_n = 1'b0;
      stab_n = 1'b0;
      rdy_n  = 1'b0;
      cnt_n  = '0;
    end else begin
      unique case (ph_q)
        PH_START: begin
          if (reached) begin
            stab_n = 1'b1;
            gate_n = 1'b1;
            wcnt_n = '0;
            ph_n   = PH_OPEN;
          end else begin
            scnt_n = scnt_q + START_W'(1);
          end
        end
        PH_OPEN: begin
          if (wcnt_q == WIN_LAST) begin
            gate_n = 1'b0;
            ph_n   = PH_WAIT;
          end else begin
            wcnt_n = wcnt_q + WIN_W'(1);
          end
        end
        PH_WAIT: begin
          if (ack_s) begin
            cnt_n = held_cnt;
            rdy_n = 1'b1;
            ph_n  = PH_DONE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_START;
      scnt_q <= '0;
      wcnt_q <= '0;
      gate_q <= 1'b0;
      stab_q <= 1'b0;
      rdy_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      ph_q   <= ph_n;
      scnt_q <= scnt_n;
      wcnt_q <= wcnt_n;
      gate_q <= gate_n;
      stab_q <= stab_n;
      rdy_q  <= rdy_n;
      cnt_q  <= cnt_n;
    end
  end

  assign gate       = gate_q;
  assign osc_stable = stab_q;
  assign meas_ready = rdy_q;
  assign meas_count = cnt_q;
endmodule

// File: rtl/osc_freq_meter.sv
module osc_freq_meter #(
  parameter int START_W = 8,
  parameter int CNT_W   = 16,
  parameter int WIN_LEN = 16
) (
  input  logic               slow_clk,
  input  logic               main_clk,
  input  logic               rst_n,
  input  logic               osc_en,
  input  logic [START_W-1:0] startup_cnt,
  output logic               osc_stable,
  output logic               meas_ready,
  output logic [CNT_W-1:0]   meas_count
);
  logic             slow_rst_n, main_rst_n;
  logic             gate, gate_s;
  logic             ack, ack_s;
  logic [CNT_W-1:0] held_cnt;

  ofm_rst_sync u_rst_slow (.clk(slow_clk), .arst_n(rst_n), .srst_n(slow_rst_n));
  ofm_rst_sync u_rst_main (.clk(main_clk), .arst_n(rst_n), .srst_n(main_rst_n));

  ofm_sync2 u_gate_sync (.clk(main_clk), .rst_n(main_rst_n), .d(gate), .q(gate_s));
  ofm_sync2 u_ack_sync  (.clk(slow_clk), .rst_n(slow_rst_n), .d(ack),  .q(ack_s));

  ofm_main_counter #(.CNT_W(CNT_W)) u_main (
    .clk      (main_clk),
    .rst_n    (main_rst_n),
    .gate_s   (gate_s),
    .held_cnt (held_cnt),
    .done_lvl (ack)
  );

  ofm_slow_ctrl #(.START_W(START_W), .CNT_W(CNT_W), .WIN_LEN(WIN_LEN)) u_slow (
    .clk         (slow_clk),
    .rst_n       (slow_rst_n),
    .osc_en      (osc_en),
    .startup_cnt (startup_cnt),
    .ack_s       (ack_s),
    .held_cnt    (held_cnt),
    .gate        (gate),
    .osc_stable  (osc_stable),
    .meas_ready  (meas_ready),
    .meas_count  (meas_count)
  );
endmodule

// File: rtl/ofm_chk.sv
module ofm_chk #(
  parameter int CNT_W = 16
) (
  input logic             slow_clk,
  input logic             rst_n,
  input logic             osc_en,
  input logic             osc_stable,
  input logic             meas_ready,
  input logic [CNT_W-1:0] meas_count
);
  // R2
  stable_cause_chk: assert property (@(posedge slow_clk) disable iff (!rst_n)
    $rose(osc_stable) |-> $past(osc_en));

  // R3
  stable_hold_chk: assert property (@(posedge slow_clk) disable iff (!rst_n)
    osc_stable && osc_en |=> osc_stable);

  // R5
  ready_needs_stable_chk: assert property (@(posedge slow_clk) disable iff (!rst_n)
    meas_ready |-> osc_stable);

  // R6
  zero_until_ready_chk: assert property (@(posedge slow_clk) disable iff (!rst_n)
    !meas_ready |-> meas_count == '0);

  // R6
  count_frozen_chk: assert property (@(posedge slow_clk) disable iff (!rst_n)
    meas_ready && osc_en |=> meas_ready && $stable(meas_count));

  // R8
  disable_clear_chk: assert property (@(posedge slow_clk) disable iff (!rst_n)
    !osc_en |=> !osc_stable && !meas_ready && meas_count == '0);
endmodule

bind osc_freq_meter ofm_chk #(.CNT_W(CNT_W)) u_chk (
  .slow_clk   (slow_clk),
  .rst_n      (rst_n),
  .osc_en     (osc_en),
  .osc_stable (osc_stable),
  .meas_ready (meas_ready),
  .meas_count (meas_count)
);

// File: tb/sim_osc_freq_meter.sv
`timescale 1ns/100ps
module sim_osc_freq_meter;
  logic        slow_clk = 1'b0;
  logic        main_clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        osc_en = 1'b0;
  logic [7:0]  startup_cnt = 8'd0;
  logic        osc_stable, meas_ready;
  logic [15:0] meas_count;

  int shalf = 40;
  int mhalf = 4;
  int compared = 0;
  int mismatched = 0;
  bit cmp_on = 1'b0;
  string tag_s = "R1", tag_r = "R1", tag_c = "R1";

  int en_edges = 0;
  int since = 0;
  bit m_stable = 1'b0;
  int exp_cnt = 0;

  osc_freq_meter u0 (
    .slow_clk(slow_clk), .main_clk(main_clk), .rst_n(rst_n), .osc_en(osc_en),
    .startup_cnt(startup_cnt), .osc_stable(osc_stable),
    .meas_ready(meas_ready), .meas_count(meas_count)
  );

  initial forever #(shalf) slow_clk = ~slow_clk;
  initial begin
    #1.5;
    forever #(mhalf) main_clk = ~main_clk;
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // behavioural reference model, advanced on every slow edge
  always @(posedge slow_clk) begin
    if (!rst_n || !osc_en) begin
      en_edges = 0; m_stable = 1'b0; since = 0;
    end else if (!m_stable) begin
      en_edges++;
      if (en_edges >= ((startup_cnt == 0) ? 1 : int'(startup_cnt))) begin
        m_stable = 1'b1; since = 0;
      end
    end else begin
      since++;
    end
  end

  always @(negedge slow_clk) begin
    if (cmp_on) begin
      bit m_ready;
      m_ready = m_stable && (since >= 19);
      chk(tag_s, "osc_stable", int'(osc_stable), int'(m_stable));
      chk(tag_r, "meas_ready", int'(meas_ready), int'(m_ready));
      chk(tag_c, "meas_count", int'(meas_count), m_ready ? exp_cnt : 0);
    end
  end

  function automatic int calc_exp();
    int v;
    v = (2 * shalf * 16) / (2 * mhalf);
    return (v > 65535) ? 65535 : v;
  endfunction

  task automatic slow_wait(input int n);
    repeat (n) @(negedge slow_clk);
  endtask

  task automatic enable(input int n);
    @(negedge slow_clk); #1;
    startup_cnt = 8'(n);
    exp_cnt = calc_exp();
    osc_en = 1'b1;
  endtask

  task automatic disable_en();
    @(negedge slow_clk); #1;
    osc_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #1_500_000;
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    // R1: outputs held at zero in reset
    cmp_on = 1'b1;
    slow_wait(5);
    rst_n = 1'b1;
    slow_wait(4);

    // R2 with 56-cycle startup, R4/R5/R6 at 8 ns main clock
    tag_s = "R2 R3"; tag_r = "R5 R6"; tag_c = "R4 R6";
    enable(56);
    slow_wait(56 + 26);
    tag_s = "R8"; tag_r = "R8"; tag_c = "R8";
    disable_en();
    slow_wait(3);

    // R4 at 10 ns main clock, short startup
    mhalf = 5;
    slow_wait(1);
    tag_s = "R2 R3"; tag_r = "R5 R6"; tag_c = "R4 R6";
    enable(3);
    slow_wait(3 + 24);
    disable_en();
    slow_wait(2);

    // R2 zero startup acts as one, R4 at 20 ns main clock
    mhalf = 10;
    slow_wait(1);
    enable(0);
    slow_wait(24);
    disable_en();
    slow_wait(2);

    // R8 abort mid-window, then R9 fresh measurement
    mhalf = 4;
    slow_wait(1);
    tag_s = "R8"; tag_r = "R8"; tag_c = "R8";
    enable(4);
    slow_wait(4 + 8);
    disable_en();
    slow_wait(3);
    tag_s = "R9"; tag_r = "R9"; tag_c = "R9";
    enable(4);
    slow_wait(4 + 24);

    // R8 disable on the very edge that would capture
    disable_en();
    slow_wait(2);
    enable(2);
    tag_s = "R8"; tag_r = "R8"; tag_c = "R8";
    do @(negedge slow_clk); while (!(m_stable && since == 18));
    #1 osc_en = 1'b0;
    slow_wait(6);

    // R7 saturation with a very slow reference
    shalf = 17000;
    slow_wait(1);
    tag_s = "R2"; tag_r = "R5"; tag_c = "R7";
    enable(1);
    slow_wait(23);
    disable_en();
    slow_wait(1);
    finish_run();
  end
endmodule